// File: doc/BRIEF.md
# I2C Bit-Level Bus Sequencer

This block is the lowest layer of a single-master I2C controller. A higher layer sends it one primitive at a time: a start condition, a stop condition, a byte to shift out, a byte to shift in, an acknowledge check, an ACK bit or a NACK bit. Each primitive is taken over a valid/ready handshake. The sequencer then plays out the matching waveform on SCL and SDA, and raises ready again when it has finished. The last received byte and the last acknowledge result are held on outputs until the next read or acknowledge check replaces them.

The waveforms are built from time units. One unit is `UNIT_TICKS` pulses of the `tick` clock-enable input, so a single divider elsewhere in the chip sets the bus rate. The low phase, the high phase, the start hold and the stop hold each take a number of units set by a parameter (8 by default). Both bus lines are open-drain. An output-enable of 1 pulls the line low, and an output-enable of 0 releases it so that the pull-up makes it high. SDA is read back through `sda_in`.

The acknowledge check samples SDA twice in the high phase. It takes the second sample only when the first one reads high, so a receiver that pulls SDA low late is still counted as acknowledging.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: After reset, both output enables are 0 (lines released) and `cmd_ready` is 1.
- R2: Opcode 0 (start) first holds SCL high and SDA released, then pulls SDA low with SCL still high, then pulls SCL low. It takes T_HIGH+T_START+T_LOW units and ends with both lines driven low.
- R3: Opcode 1 (stop) pulls both lines low, then releases SCL, then releases SDA while SCL is high. It takes 2*T_LOW+2*T_HIGH+T_STOP units and ends with both lines released.
- R4: Opcode 2 (write) sends `cmd_byte` MSB first, with each bit valid at the rising edge of SCL. It then drives SDA low for T_LOW/2 units. It takes 8*(T_LOW+T_HIGH)+T_LOW/2 units and ends with SCL low and SDA released.
- R5: Opcode 3 (read) keeps SDA released and samples it in the middle of each of 8 high phases. It collects the bits MSB first into `rx_byte`, takes 8*(T_LOW+T_HIGH) units and ends with SCL low.
- R6: Opcode 4 (acknowledge check) sets `ack_seen` to 1 when SDA is low at the first sample, half a high phase after SCL rises. In that case it skips the second sample and takes T_HIGH+T_LOW/2 units.
- R7: When the first sample of opcode 4 reads high, a second sample follows half a high phase later. `ack_seen` is 1 if that sample is low and 0 if it is high. Either way the command takes 3*T_HIGH/2+T_LOW/2 units.
- R8: Opcode 5 (ACK) drives SDA low across one full SCL high pulse. Opcode 6 (NACK) keeps SDA released across that pulse. Both release SDA afterwards and take 2*T_LOW+T_HIGH+T_LOW/4 units.
- R9: The sequencer's SDA output-enable never changes while SCL stays high, except inside a start or stop command. A write, a read, an acknowledge check or an ACK/NACK therefore never produces a start or stop condition on the bus.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from acceptance until the command completes.
- R11: Bus timing advances only on cycles where `tick` is 1. A command cannot complete in a cycle without a tick, and slowing the tick rate stretches the command by the same factor.
- R12: Opcode 7 is not a command. It is never accepted, `cmd_ready` stays 1 and the bus lines do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that paces bus timing |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to accept a command |
| cmd_op | input | 3 | Opcode: 0 start, 1 stop, 2 write, 3 read, 4 check ack, 5 ACK, 6 NACK |
| cmd_byte | input | 8 | Byte to send with opcode 2 |
| rx_byte | output | 8 | Last byte received by opcode 3 |
| ack_seen | output | 1 | Result of the last acknowledge check (1 = acknowledged) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA level read back from the bus |

## Verification
The bench drives a small responder on the open-drain bus. It is used in three acknowledge patterns: pulled low before SCL rises, pulled low only between the two samples, and never pulled low. Together these show whether the second sample exists and whether the early-exit path shortens the command. Bytes with mixed bit patterns (0xA5, 0x3C, 0x96, 0x5A) separate MSB-first order from LSB-first order and catch bits that are stuck or swapped, for writes and reads alike. A bus monitor counts start and stop conditions, so any SDA edge that lands while SCL is high outside start or stop is caught. Command lengths measured under a slower tick rate confirm that timing follows the clock-enable.

// File: rtl/i2c_bit_sequencer.sv
`timescale 1ns/1ps
module i2c_bit_sequencer #(
  parameter int UNIT_TICKS = 2,
  parameter int T_LOW      = 8,
  parameter int T_HIGH     = 8,
  parameter int T_START    = 8,
  parameter int T_STOP     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_byte,
  output logic [7:0] rx_byte,
  output logic       ack_seen,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_STOP  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_CHECK = 3'd4;
  localparam logic [2:0] OP_ACK   = 3'd5;
  localparam logic [2:0] OP_NACK  = 3'd6;
  localparam logic [2:0] OP_NONE  = 3'd7;

  localparam int TW   = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int MAXU = 2*T_LOW + 2*T_HIGH + T_START + T_STOP;
  localparam int UW   = $clog2(MAXU + 1);

  logic          busy;
  logic [2:0]    op_q;
  logic [2:0]    ph;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    rx_q;
  logic          ack_q;
  logic [TW-1:0] tcnt;
  logic [UW-1:0] ucnt;
  logic          scl_q, sda_q;

  logic          scl_d, sda_d;
  logic [UW-1:0] len;
  logic [2:0]    nxt_ph;
  logic          fin;
  logic          unit_end, ph_end;
  logic          ackbit;

  assign cmd_ready = !busy;
  assign scl_oe    = !scl_q;
  assign sda_oe    = !sda_q;
  assign rx_byte   = rx_q;
  assign ack_seen  = ack_q;
  assign ackbit    = (op_q == OP_NACK);
  assign unit_end  = tick && (tcnt == TW'(UNIT_TICKS - 1));
  assign ph_end    = unit_end && (ucnt == len - UW'(1));

  // levels and length of the current phase
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b1;
    len   = UW'(T_LOW);
    case (op_q)
      OP_START: begin
        case (ph)
          3'd0:    begin scl_d = 1'b1; sda_d = 1'b1; len = UW'(T_HIGH);  end
          3'd1:    begin scl_d = 1'b1; sda_d = 1'b0; len = UW'(T_START); end
          default: begin scl_d = 1'b0; sda_d = 1'b0; len = UW'(T_LOW);   end
        endcase
      end
      OP_STOP: begin
        case (ph)
          3'd0:    begin scl_d = 1'b0; sda_d = 1'b0; len = UW'(2*T_LOW);  end
          3'd1:    begin scl_d = 1'b1; sda_d = 1'b0; len = UW'(2*T_HIGH); end
          default: begin scl_d = 1'b1; sda_d = 1'b1; len = UW'(T_STOP);   end
        endcase
      end
      OP_WRITE: begin
        case (ph)
          3'd0:    begin scl_d = 1'b0; sda_d = sh[7]; len = UW'(T_LOW/2); end
          3'd1:    begin scl_d = 1'b1; sda_d = sh[7]; len = UW'(T_HIGH);  end
          3'd2:    begin scl_d = 1'b0; sda_d = sh[7]; len = UW'(T_LOW/2); end
          default: begin scl_d = 1'b0; sda_d = 1'b0;  len = UW'(T_LOW/2); end
        endcase
      end
      OP_READ: begin
        case (ph)
          3'd0:    begin scl_d = 1'b0; len = UW'(T_LOW/2);  end
          3'd1:    begin scl_d = 1'b1; len = UW'(T_HIGH/2); end
          3'd2:    begin scl_d = 1'b1; len = UW'(T_HIGH/2); end
          default: begin scl_d = 1'b0; len = UW'(T_LOW/2);  end
        endcase
      end
      OP_CHECK: begin
        case (ph)
          3'd0:    begin scl_d = 1'b0; len = UW'(T_HIGH/4); end
          3'd1:    begin scl_d = 1'b1; len = UW'(T_HIGH/2); end
          3'd2:    begin scl_d = 1'b1; len = UW'(T_HIGH/2); end
          3'd3:    begin scl_d = 1'b0; len = UW'(T_HIGH/4); end
          default: begin scl_d = 1'b0; len = UW'(T_LOW/2);  end
        endcase
      end
      OP_ACK, OP_NACK: begin
        case (ph)
          3'd0:    begin scl_d = 1'b0; sda_d = ackbit; len = UW'(T_LOW);   end
          3'd1:    begin scl_d = 1'b1; sda_d = ackbit; len = UW'(T_HIGH);  end
          3'd2:    begin scl_d = 1'b0; sda_d = ackbit; len = UW'(T_LOW/4); end
          default: begin scl_d = 1'b0; sda_d = 1'b1;   len = UW'(T_LOW);   end
        endcase
      end
      default: begin scl_d = scl_q; sda_d = sda_q; end
    endcase
  end

  // phase ordering
  always_comb begin
    nxt_ph = ph + 3'd1;
    fin    = 1'b0;
    case (op_q)
      OP_START, OP_STOP: fin = (ph == 3'd2);
      OP_WRITE: begin
        if (ph == 3'd2 && bitn != 3'd7) nxt_ph = 3'd0;
        fin = (ph == 3'd3);
      end
      OP_READ: begin
        if (ph == 3'd3) begin
          if (bitn == 3'd7) fin = 1'b1;
          else              nxt_ph = 3'd0;
        end
      end
      OP_CHECK: begin
        if (ph == 3'd1 && !sda_in) nxt_ph = 3'd3;
        fin = (ph == 3'd4);
      end
      OP_ACK, OP_NACK: fin = (ph == 3'd3);
      default: fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op_q  <= OP_START;
      ph    <= '0;
      bitn  <= '0;
      sh    <= '0;
      rx_q  <= '0;
      ack_q <= 1'b0;
      tcnt  <= '0;
      ucnt  <= '0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (!busy) begin
      if (cmd_valid && cmd_op != OP_NONE) begin
        busy <= 1'b1;
        op_q <= cmd_op;
        ph   <= '0;
        bitn <= '0;
        tcnt <= '0;
        ucnt <= '0;
        if (cmd_op == OP_WRITE) sh    <= cmd_byte;
        if (cmd_op == OP_CHECK) ack_q <= 1'b0;
      end
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
      if (tick) begin
        if (!unit_end)    tcnt <= tcnt + TW'(1);
        else              tcnt <= '0;
      end
      if (unit_end) begin
        if (!ph_end) ucnt <= ucnt + UW'(1);
        else         ucnt <= '0;
      end
      if (ph_end) begin
        if (op_q == OP_READ && ph == 3'd1)
          rx_q <= {rx_q[6:0], sda_in};
        if (op_q == OP_READ && ph == 3'd3)
          bitn <= bitn + 3'd1;
        if (op_q == OP_CHECK && (ph == 3'd1 || ph == 3'd2) && !sda_in)
          ack_q <= 1'b1;
        if (op_q == OP_WRITE && ph == 3'd2) begin
          sh   <= {sh[6:0], 1'b0};
          bitn <= bitn + 3'd1;
        end
        if (fin) begin
          busy <= 1'b0;
          if (op_q != OP_START) sda_q <= 1'b1;
        end else begin
          ph <= nxt_ph;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_seq_checks.sv
`timescale 1ns/1ps
module i2c_seq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] op_q
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (cmd_ready && !scl_oe && !sda_oe)); // R1

  AST_START_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_ready) && op_q == 3'd0) |-> (scl_oe && sda_oe)); // R2

  AST_STOP_ENDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_ready) && op_q == 3'd1) |-> (!scl_oe && !sda_oe)); // R3

  AST_SDA_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && op_q != 3'd0 && op_q != 3'd1) |-> $stable(sda_oe)); // R9

  AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ready) |-> $past(cmd_valid)); // R10

  AST_NO_DONE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !tick) |=> !cmd_ready); // R11

  AST_OPCODE7_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && cmd_op == 3'd7) |=> cmd_ready); // R12

endmodule

bind i2c_bit_sequencer i2c_seq_checks u_seq_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .op_q      (op_q)
);

// File: tb/test_i2c_bit_sequencer.sv
`timescale 1ns/1ps
module test_i2c_bit_sequencer;

  localparam int UT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       ack_seen;
  logic       scl_oe, sda_oe;
  logic       slave_low = 1'b0;
  logic       scl_bus, sda_bus;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  int stops  = 0;
  bit mon_en = 1'b1;
  int tdiv   = 1;
  logic [3:0] tc = '0;

  always #5 clk = ~clk;

  always @(posedge clk) tc <= (int'(tc) >= tdiv - 1) ? 4'd0 : tc + 4'd1;
  assign tick = (tc == 4'd0);

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || slave_low);

  always @(negedge sda_bus) if (mon_en && scl_bus === 1'b1) starts++;
  always @(posedge sda_bus) if (mon_en && scl_bus === 1'b1) stops++;

  i2c_bit_sequencer #(.UNIT_TICKS(UT)) i_i2c_bit_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rx_byte(rx_byte), .ack_seen(ack_seen),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] b, output int n);
    @(negedge clk);
    cmd_op = op; cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!cmd_ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(cmd_ready === 1'b1, "R1 ready", int'(cmd_ready), 1);
    check(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 lines", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_start;
    int n, s0, p0;
    s0 = starts; p0 = stops;
    run_cmd(3'd0, 8'h00, n);
    check(n == 24*UT, "R2 duration", n, 24*UT);
    check(starts - s0 == 1 && stops == p0, "R2 start count", starts - s0, 1);
    check(scl_oe && sda_oe, "R2 end levels", int'({scl_oe, sda_oe}), 3);
    check(n > 1, "R10 ready low while busy", n, 24*UT);
  endtask

  task automatic t_write(input logic [7:0] b);
    int n, s0, p0;
    logic [7:0] cap;
    s0 = starts; p0 = stops; cap = '0;
    fork
      run_cmd(3'd2, b, n);
      for (int i = 0; i < 8; i++) begin
        @(posedge scl_bus);
        cap = {cap[6:0], sda_bus};
      end
    join
    check(cap == b, "R4 bits msb first", int'(cap), int'(b));
    check(n == 132*UT, "R4 duration", n, 132*UT);
    check(scl_oe && !sda_oe, "R4 end levels", int'({scl_oe, sda_oe}), 2);
    check(starts == s0 && stops == p0, "R9 no false condition in write", starts + stops, s0 + p0);
  endtask

  task automatic t_ack_early;
    int n;
    slave_low = 1'b1;
    run_cmd(3'd4, 8'h00, n);
    slave_low = 1'b0;
    check(ack_seen === 1'b1, "R6 ack early", int'(ack_seen), 1);
    check(n == 12*UT, "R6 short duration", n, 12*UT);
  endtask

  task automatic t_ack_late;
    int n;
    mon_en = 1'b0;
    fork
      run_cmd(3'd4, 8'h00, n);
      begin
        @(posedge scl_bus);
        repeat (10) @(posedge clk);
        #1 slave_low = 1'b1;
        @(negedge scl_bus);
        slave_low = 1'b0;
      end
    join
    mon_en = 1'b1;
    check(ack_seen === 1'b1, "R7 late ack counted", int'(ack_seen), 1);
    check(n == 16*UT, "R7 late duration", n, 16*UT);
  endtask

  task automatic t_ack_none;
    int n;
    run_cmd(3'd4, 8'h00, n);
    check(ack_seen === 1'b0, "R7 no ack", int'(ack_seen), 0);
    check(n == 16*UT, "R7 no-ack duration", n, 16*UT);
  endtask

  task automatic t_read(input logic [7:0] b);
    int n, s0, p0;
    s0 = starts; p0 = stops;
    slave_low = !b[7];
    fork
      run_cmd(3'd3, 8'h00, n);
      for (int i = 7; i >= 0; i--) begin
        @(negedge scl_bus);
        slave_low = (i > 0) ? !b[i-1] : 1'b0;
      end
    join
    slave_low = 1'b0;
    check(rx_byte == b, "R5 received byte", int'(rx_byte), int'(b));
    check(n == 128*UT, "R5 duration", n, 128*UT);
    check(scl_oe === 1'b1 && sda_oe === 1'b0, "R5 end levels", int'({scl_oe, sda_oe}), 2);
    check(starts == s0 && stops == p0, "R9 no false condition in read", starts + stops, s0 + p0);
  endtask

  task automatic t_send(input logic [2:0] op);
    int n;
    logic v;
    v = 1'bx;
    fork
      run_cmd(op, 8'h00, n);
      begin @(posedge scl_bus); #1 v = sda_bus; end
    join
    if (op == 3'd5) check(v === 1'b0, "R8 ACK low in pulse", int'(v), 0);
    else            check(v === 1'b1, "R8 NACK high in pulse", int'(v), 1);
    check(n == 26*UT, "R8 duration", n, 26*UT);
    check(sda_oe === 1'b0 && scl_oe === 1'b1, "R8 end levels", int'({scl_oe, sda_oe}), 2);
  endtask

  task automatic t_stop;
    int n, s0, p0;
    s0 = starts; p0 = stops;
    run_cmd(3'd1, 8'h00, n);
    check(n == 40*UT, "R3 duration", n, 40*UT);
    check(stops - p0 == 1 && starts == s0, "R3 stop count", stops - p0, 1);
    check(!scl_oe && !sda_oe, "R3 end levels", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_bad_op;
    logic so, ao;
    int s0, p0;
    so = scl_oe; ao = sda_oe; s0 = starts; p0 = stops;
    @(negedge clk);
    cmd_op = 3'd7; cmd_valid = 1'b1;
    repeat (6) @(negedge clk);
    check(cmd_ready === 1'b1, "R12 opcode 7 not accepted", int'(cmd_ready), 1);
    check(scl_oe == so && sda_oe == ao && starts == s0 && stops == p0,
          "R12 bus unchanged", int'({scl_oe, sda_oe}), int'({so, ao}));
    cmd_valid = 1'b0;
  endtask

  task automatic t_slow_tick;
    int n;
    tdiv = 3;
    run_cmd(3'd0, 8'h00, n);
    check(n >= (24*UT - 1)*3 + 1 && n <= 24*UT*3, "R11 start stretched by tick rate", n, 24*UT*3);
    run_cmd(3'd1, 8'h00, n);
    check(n >= (40*UT - 1)*3 + 1 && n <= 40*UT*3, "R11 stop stretched by tick rate", n, 40*UT*3);
    tdiv = 1;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_start;
    t_write(8'hA5);
    t_ack_early;
    t_write(8'h3C);
    t_ack_late;
    t_ack_none;
    t_stop;
    t_start;
    t_write(8'hA1);
    t_ack_early;
    t_read(8'h96);
    t_send(3'd5);
    t_read(8'h5A);
    t_send(3'd6);
    t_stop;
    t_bad_op;
    t_slow_tick;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule